// File: doc/BRIEF.md
# Reorder Buffer with Precise Exception Flush

This block sits between decode and the architectural state of an in-order-issue core whose functional units finish out of order. Decode reserves one entry per instruction in program order and gets back an entry tag. Functional units later report a result, an optional store address and an exception flag against that tag through two completion ports. The oldest entry leaves the buffer only once it has completed. Then either its register write or its store is presented at the commit outputs, or, if it faulted, the whole buffer is discarded and fetch is sent to a fixed handler address.

A rename table holds one pending bit and one entry tag for each architectural register. It records the youngest in-flight producer of each register. An operand lookup reads that mapping and returns the producer's result directly, with no associative search. A result arriving on a completion port in the same cycle is forwarded into the lookup. Commit outputs, flush and lookup are combinational from the current state. All state changes happen on the rising clock edge.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `allocReady` is 1, `allocTag` is 0, `rfWrEn`, `stWrEn` and `flushOut` are 0, and `lookupPending` is 0 for every register.
- R2: Each accepted allocation returns the tag one above the previous one, modulo 16. Tags are handed out in program order.
- R3: With 16 entries held, `allocReady` is 0, and `allocValid` is ignored: `allocTag` is unchanged afterwards.
- R4: Each of the two completion ports writes data, store address and exception flag into the entry named by its tag. Results may arrive in any order, and the committed data is the data written for that entry.
- R5: Only the oldest entry commits, and only once it has completed without exception. A register writer drives `rfWrEn`, `rfWrReg` and `rfWrData` for that cycle. A store (which never has a destination) drives `stWrEn`, `stWrAddr` and `stWrData` instead.
- R6: An entry that neither writes a register nor stores retires with both `rfWrEn` and `stWrEn` low, and still frees its slot.
- R7: When the oldest entry has completed with its exception flag set, `flushOut` is 1, `faultPc` is that entry's PC and `redirectPc` is the handler vector (default 0x100). Neither write port fires. On the next cycle the buffer is empty, every mapping is cleared, and the next tag handed out is the faulting entry's tag.
- R8: `lookupPending` shows whether a register has an in-flight producer, and `lookupTag` names the youngest one. When that entry has completed, `lookupReady` is 1 and `lookupValue` is its data.
- R9: When a completion port writes the looked-up producer in the same cycle, `lookupReady` is 1 and `lookupValue` is the data on that port.
- R10: At commit, a register's mapping is cleared only if it still names the committing entry. A younger producer's mapping survives.
- R11: In a flush cycle `allocReady` is 0 and no allocation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Decode requests an entry |
| allocIsStore | input | 1 | New entry is a store |
| allocHasDest | input | 1 | New entry writes a register |
| allocDest | input | 4 | Destination register of the new entry |
| allocPc | input | 32 | PC of the new entry |
| allocReady | output | 1 | Entry can be taken this cycle |
| allocTag | output | 4 | Tag the next allocation receives |
| cmplValid | input | 2 | Per-port completion strobe |
| cmplTag | input | 2x4 | Per-port target entry tag |
| cmplData | input | 2x32 | Per-port result or store data |
| cmplAddr | input | 2x32 | Per-port store address |
| cmplExc | input | 2 | Per-port exception flag |
| lookupReg | input | 4 | Register to look up |
| lookupPending | output | 1 | Register has an in-flight producer |
| lookupTag | output | 4 | Tag of that producer |
| lookupReady | output | 1 | Producer's result is available |
| lookupValue | output | 32 | Producer's result |
| rfWrEn | output | 1 | Register file write at commit |
| rfWrReg | output | 4 | Register written |
| rfWrData | output | 32 | Data written |
| stWrEn | output | 1 | Memory store at commit |
| stWrAddr | output | 32 | Store address |
| stWrData | output | 32 | Store data |
| flushOut | output | 1 | Oldest entry faulted; buffer is discarded |
| faultPc | output | 32 | PC of the faulting entry |
| redirectPc | output | 32 | Handler vector for fetch |

## Verification
A corrupted head or tail pointer shows within one cycle: `allocTag` skips or repeats, or commits appear out of program order on the write ports. A stale done or exception bit shows up the first time that slot reaches the head, as a premature or missing commit or a spurious flush. A rename entry left set after a flush, or cleared by an older commit, shows as a wrong `lookupPending` or `lookupTag` on the next lookup of that register. Random traffic with frequent lookups therefore brings most corruptions out within a few cycles.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned DefDepth    = 16;
  localparam int unsigned DefNumCmpl  = 2;
  localparam int unsigned DefXlen     = 32;
  localparam int unsigned DefArchRegs = 16;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic allocFire;
    logic commitFire;
    logic flushFire;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = DefDepth
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     allocValid,
  input  logic                     headDone,
  input  logic                     headExc,
  output robStrobe_t               strobe,
  output logic [$clog2(DEPTH)-1:0] headTag,
  output logic [$clog2(DEPTH)-1:0] tailTag,
  output logic                     allocReady
);
  localparam int unsigned TAG_W = $clog2(DEPTH);
  localparam int unsigned PTR_W = TAG_W + 1;

  logic [PTR_W-1:0] headPtr, tailPtr, occ;
  logic full, empty, headEligible;

  assign occ          = tailPtr - headPtr;
  assign full         = (occ == PTR_W'(DEPTH));
  assign empty        = (occ == '0);
  assign headEligible = !empty && headDone;

  assign strobe.commitFire = headEligible && !headExc;
  assign strobe.flushFire  = headEligible && headExc;
  assign allocReady        = !full && !strobe.flushFire;
  assign strobe.allocFire  = allocValid && allocReady;

  assign headTag = headPtr[TAG_W-1:0];
  assign tailTag = tailPtr[TAG_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (strobe.flushFire) begin
      tailPtr <= headPtr;
    end else begin
      if (strobe.commitFire) headPtr <= headPtr + PTR_W'(1);
      if (strobe.allocFire)  tailPtr <= tailPtr + PTR_W'(1);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occ <= PTR_W'(DEPTH));

  a_r7_empty_after_flush: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushFire |=> (tailPtr == headPtr));

  a_r5_head_steps_once: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitFire |=> (headPtr == $past(headPtr) + PTR_W'(1)));

  a_r2_tail_steps_once: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocFire |=> (tailPtr == $past(tailPtr) + PTR_W'(1)));
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH     = DefDepth,
  parameter int unsigned NUM_CMPL  = DefNumCmpl,
  parameter int unsigned XLEN      = DefXlen,
  parameter int unsigned ARCH_REGS = DefArchRegs
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  robStrobe_t                               strobe,
  input  logic [$clog2(DEPTH)-1:0]                 headTag,
  input  logic [$clog2(DEPTH)-1:0]                 tailTag,
  input  logic                                     allocIsStore,
  input  logic                                     allocHasDest,
  input  logic [$clog2(ARCH_REGS)-1:0]             allocDest,
  input  logic [XLEN-1:0]                          allocPc,
  input  logic [NUM_CMPL-1:0]                      cmplValid,
  input  logic [NUM_CMPL-1:0][$clog2(DEPTH)-1:0]   cmplTag,
  input  logic [NUM_CMPL-1:0][XLEN-1:0]            cmplData,
  input  logic [NUM_CMPL-1:0][XLEN-1:0]            cmplAddr,
  input  logic [NUM_CMPL-1:0]                      cmplExc,
  input  logic [$clog2(ARCH_REGS)-1:0]             lookupReg,
  output logic                                     headDone,
  output logic                                     headExc,
  output logic                                     lookupPending,
  output logic [$clog2(DEPTH)-1:0]                 lookupTag,
  output logic                                     lookupReady,
  output logic [XLEN-1:0]                          lookupValue,
  output logic                                     rfWrEn,
  output logic [$clog2(ARCH_REGS)-1:0]             rfWrReg,
  output logic [XLEN-1:0]                          rfWrData,
  output logic                                     stWrEn,
  output logic [XLEN-1:0]                          stWrAddr,
  output logic [XLEN-1:0]                          stWrData,
  output logic [XLEN-1:0]                          faultPc
);
  localparam int unsigned TAG_W = $clog2(DEPTH);
  localparam int unsigned REG_W = $clog2(ARCH_REGS);

  // Entry state
  logic [DEPTH-1:0] doneQ, excQ, storeQ, hasDestQ;
  logic [REG_W-1:0] destQ [DEPTH];
  logic [XLEN-1:0]  valQ  [DEPTH];
  logic [XLEN-1:0]  addrQ [DEPTH];
  logic [XLEN-1:0]  pcQ   [DEPTH];

  // Rename table
  logic [ARCH_REGS-1:0] mapPend;
  logic [TAG_W-1:0]     mapTag [ARCH_REGS];

  // Completion-to-lookup forwarding
  logic [NUM_CMPL-1:0] fwdHit;
  logic                fwdAny;
  logic [XLEN-1:0]     fwdVal;

  // Status flags: flush wipes, allocation clears, completion sets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= '0;
      excQ  <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (strobe.flushFire) begin
          doneQ[e] <= 1'b0;
          excQ[e]  <= 1'b0;
        end else if (strobe.allocFire && tailTag == TAG_W'(e)) begin
          doneQ[e] <= 1'b0;
          excQ[e]  <= 1'b0;
        end else begin
          for (int k = 0; k < NUM_CMPL; k++) begin
            if (cmplValid[k] && cmplTag[k] == TAG_W'(e)) begin
              doneQ[e] <= 1'b1;
              excQ[e]  <= cmplExc[k];
            end
          end
        end
      end
    end
  end

  // Payload: written at allocation and at completion, needs no reset
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (strobe.allocFire && tailTag == TAG_W'(e)) begin
        storeQ[e]   <= allocIsStore;
        hasDestQ[e] <= allocHasDest && !allocIsStore;
        destQ[e]    <= allocDest;
        pcQ[e]      <= allocPc;
      end
      for (int k = 0; k < NUM_CMPL; k++) begin
        if (cmplValid[k] && cmplTag[k] == TAG_W'(e)) begin
          valQ[e]  <= cmplData[k];
          addrQ[e] <= cmplAddr[k];
        end
      end
    end
  end

  // Rename table: a newer allocation overrides a clear from commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapPend <= '0;
      for (int r = 0; r < ARCH_REGS; r++) mapTag[r] <= '0;
    end else if (strobe.flushFire) begin
      mapPend <= '0;
    end else begin
      if (strobe.commitFire && hasDestQ[headTag] &&
          mapTag[destQ[headTag]] == headTag)
        mapPend[destQ[headTag]] <= 1'b0;
      if (strobe.allocFire && allocHasDest && !allocIsStore) begin
        mapPend[allocDest] <= 1'b1;
        mapTag[allocDest]  <= tailTag;
      end
    end
  end

  assign headDone = doneQ[headTag];
  assign headExc  = excQ[headTag];

  // Commit ports
  assign rfWrEn   = strobe.commitFire && hasDestQ[headTag];
  assign rfWrReg  = destQ[headTag];
  assign rfWrData = valQ[headTag];
  assign stWrEn   = strobe.commitFire && storeQ[headTag];
  assign stWrAddr = addrQ[headTag];
  assign stWrData = valQ[headTag];
  assign faultPc  = pcQ[headTag];

  // Operand lookup
  assign lookupPending = mapPend[lookupReg];
  assign lookupTag     = mapTag[lookupReg];

  for (genvar k = 0; k < NUM_CMPL; k++) begin : g_port
    assign fwdHit[k] = cmplValid[k] && (cmplTag[k] == lookupTag);

    a_r4_completion_marks_done: assert property (@(posedge clk) disable iff (!rstN)
      (cmplValid[k] && !strobe.flushFire) |=> doneQ[$past(cmplTag[k])]);
  end

  always_comb begin
    fwdAny = 1'b0;
    fwdVal = '0;
    for (int k = 0; k < NUM_CMPL; k++) begin
      if (fwdHit[k]) begin
        fwdAny = 1'b1;
        fwdVal = cmplData[k];
      end
    end
  end

  always_comb begin
    lookupReady = 1'b0;
    lookupValue = '0;
    if (lookupPending) begin
      if (doneQ[lookupTag]) begin
        lookupReady = 1'b1;
        lookupValue = valQ[lookupTag];
      end else if (fwdAny) begin
        lookupReady = 1'b1;
        lookupValue = fwdVal;
      end
    end
  end

  a_r8_alloc_maps_dest: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.allocFire && allocHasDest && !allocIsStore) |=>
      (mapPend[$past(allocDest)] && mapTag[$past(allocDest)] == $past(tailTag)));

  a_r7_flush_clears_map: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushFire |=> (mapPend == '0));
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int unsigned     DEPTH       = DefDepth,
  parameter int unsigned     NUM_CMPL    = DefNumCmpl,
  parameter int unsigned     XLEN        = DefXlen,
  parameter int unsigned     ARCH_REGS   = DefArchRegs,
  parameter logic [XLEN-1:0] HANDLER_VEC = XLEN'(32'h0000_0100)
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   allocValid,
  input  logic                                   allocIsStore,
  input  logic                                   allocHasDest,
  input  logic [$clog2(ARCH_REGS)-1:0]           allocDest,
  input  logic [XLEN-1:0]                        allocPc,
  output logic                                   allocReady,
  output logic [$clog2(DEPTH)-1:0]               allocTag,
  input  logic [NUM_CMPL-1:0]                    cmplValid,
  input  logic [NUM_CMPL-1:0][$clog2(DEPTH)-1:0] cmplTag,
  input  logic [NUM_CMPL-1:0][XLEN-1:0]          cmplData,
  input  logic [NUM_CMPL-1:0][XLEN-1:0]          cmplAddr,
  input  logic [NUM_CMPL-1:0]                    cmplExc,
  input  logic [$clog2(ARCH_REGS)-1:0]           lookupReg,
  output logic                                   lookupPending,
  output logic [$clog2(DEPTH)-1:0]               lookupTag,
  output logic                                   lookupReady,
  output logic [XLEN-1:0]                        lookupValue,
  output logic                                   rfWrEn,
  output logic [$clog2(ARCH_REGS)-1:0]           rfWrReg,
  output logic [XLEN-1:0]                        rfWrData,
  output logic                                   stWrEn,
  output logic [XLEN-1:0]                        stWrAddr,
  output logic [XLEN-1:0]                        stWrData,
  output logic                                   flushOut,
  output logic [XLEN-1:0]                        faultPc,
  output logic [XLEN-1:0]                        redirectPc
);
  robStrobe_t                strobe;
  logic [$clog2(DEPTH)-1:0]  headTag, tailTag;
  logic                      headDone, headExc;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .headDone   (headDone),
    .headExc    (headExc),
    .strobe     (strobe),
    .headTag    (headTag),
    .tailTag    (tailTag),
    .allocReady (allocReady)
  );

  rob_data #(
    .DEPTH     (DEPTH),
    .NUM_CMPL  (NUM_CMPL),
    .XLEN      (XLEN),
    .ARCH_REGS (ARCH_REGS)
  ) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .headTag       (headTag),
    .tailTag       (tailTag),
    .allocIsStore  (allocIsStore),
    .allocHasDest  (allocHasDest),
    .allocDest     (allocDest),
    .allocPc       (allocPc),
    .cmplValid     (cmplValid),
    .cmplTag       (cmplTag),
    .cmplData      (cmplData),
    .cmplAddr      (cmplAddr),
    .cmplExc       (cmplExc),
    .lookupReg     (lookupReg),
    .headDone      (headDone),
    .headExc       (headExc),
    .lookupPending (lookupPending),
    .lookupTag     (lookupTag),
    .lookupReady   (lookupReady),
    .lookupValue   (lookupValue),
    .rfWrEn        (rfWrEn),
    .rfWrReg       (rfWrReg),
    .rfWrData      (rfWrData),
    .stWrEn        (stWrEn),
    .stWrAddr      (stWrAddr),
    .stWrData      (stWrData),
    .faultPc       (faultPc)
  );

  assign allocTag   = tailTag;
  assign flushOut   = strobe.flushFire;
  assign redirectPc = HANDLER_VEC;

  a_r11_no_alloc_in_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> !allocReady);
endmodule

// File: tb/reorder_buf_test.sv
module reorder_buf_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ND = 16;
  localparam logic [31:0] HVEC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rstN;
  always #4 clk = ~clk;   // 125 MHz

  logic        allocValid, allocIsStore, allocHasDest, allocReady;
  logic [3:0]  allocDest, allocTag;
  logic [31:0] allocPc;
  logic [1:0]        cmplValid, cmplExc;
  logic [1:0][3:0]   cmplTag;
  logic [1:0][31:0]  cmplData, cmplAddr;
  logic [3:0]  lookupReg, lookupTag, rfWrReg;
  logic        lookupPending, lookupReady, rfWrEn, stWrEn, flushOut;
  logic [31:0] lookupValue, rfWrData, stWrAddr, stWrData, faultPc, redirectPc;

  reorder_buf uut (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocIsStore(allocIsStore), .allocHasDest(allocHasDest),
    .allocDest(allocDest), .allocPc(allocPc), .allocReady(allocReady), .allocTag(allocTag),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplData(cmplData), .cmplAddr(cmplAddr),
    .cmplExc(cmplExc), .lookupReg(lookupReg), .lookupPending(lookupPending),
    .lookupTag(lookupTag), .lookupReady(lookupReady), .lookupValue(lookupValue),
    .rfWrEn(rfWrEn), .rfWrReg(rfWrReg), .rfWrData(rfWrData), .stWrEn(stWrEn),
    .stWrAddr(stWrAddr), .stWrData(stWrData), .flushOut(flushOut), .faultPc(faultPc),
    .redirectPc(redirectPc)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model of the requirements
  bit          mDone[ND], mExc[ND], mSt[ND], mHd[ND];
  logic [3:0]  mDst[ND];
  logic [31:0] mVal[ND], mAddr[ND], mPc[ND];
  bit          mapP[ND];
  int          mapT[ND];
  int          mHead = 0, mTail = 0, mCount = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 0; allocIsStore = 0; allocHasDest = 0; allocDest = 0; allocPc = 0;
    cmplValid = 0; cmplExc = 0; cmplTag = '0; cmplData = '0; cmplAddr = '0;
    lookupReg = 0;
  endtask

  // Inputs are set at a falling edge; compare just before the rising edge,
  // then advance the model with what fired at that edge.
  task automatic stepCycle();
    int h, t;
    bit full, elig, eC, eF, eR, eRf, eSt, aF, fwd;
    logic [31:0] fv;
    string rq;
    #2;
    h    = mHead;
    full = (mCount == ND);
    elig = (mCount > 0) && mDone[h];
    eC   = elig && !mExc[h];
    eF   = elig && mExc[h];
    eR   = !full && !eF;
    chk(eF ? "R11" : "R3", "allocReady", allocReady, eR);
    if (eR) chk("R2", "allocTag", allocTag, mTail);
    chk("R7", "flushOut", flushOut, eF);
    if (eF) begin
      chk("R7", "faultPc", faultPc, mPc[h]);
      chk("R7", "redirectPc", redirectPc, HVEC);
    end
    eRf = eC && mHd[h] && !mSt[h];
    eSt = eC && mSt[h];
    rq  = (eC && !mHd[h] && !mSt[h]) ? "R6" : "R5";
    chk(rq, "rfWrEn", rfWrEn, eRf);
    chk(rq, "stWrEn", stWrEn, eSt);
    if (eRf) begin
      chk("R5", "rfWrReg", rfWrReg, mDst[h]);
      chk("R4", "rfWrData", rfWrData, mVal[h]);
    end
    if (eSt) begin
      chk("R5", "stWrAddr", stWrAddr, mAddr[h]);
      chk("R4", "stWrData", stWrData, mVal[h]);
    end
    chk("R8", "lookupPending", lookupPending, mapP[lookupReg]);
    if (mapP[lookupReg]) begin
      t = mapT[lookupReg];
      chk("R8", "lookupTag", lookupTag, t);
      fwd = 0; fv = 0;
      for (int k = 0; k < 2; k++)
        if (cmplValid[k] && cmplTag[k] == t) begin fwd = 1; fv = cmplData[k]; end
      rq = (!mDone[t] && fwd) ? "R9" : "R8";
      chk(rq, "lookupReady", lookupReady, mDone[t] || fwd);
      if (mDone[t]) chk(rq, "lookupValue", lookupValue, mVal[t]);
      else if (fwd) chk(rq, "lookupValue", lookupValue, fv);
    end
    aF = allocValid && eR;
    @(posedge clk);
    if (eF) begin
      mCount = 0; mTail = mHead;
      for (int r = 0; r < ND; r++) mapP[r] = 0;
    end else begin
      for (int k = 0; k < 2; k++)
        if (cmplValid[k]) begin
          t = cmplTag[k];
          mDone[t] = 1; mExc[t] = cmplExc[k]; mVal[t] = cmplData[k]; mAddr[t] = cmplAddr[k];
        end
      if (eC) begin
        if (mHd[h] && mapP[mDst[h]] && mapT[mDst[h]] == h) mapP[mDst[h]] = 0;
        mHead = (mHead + 1) % ND; mCount--;
      end
      if (aF) begin
        mDone[mTail] = 0; mExc[mTail] = 0; mSt[mTail] = allocIsStore;
        mHd[mTail] = allocHasDest && !allocIsStore; mDst[mTail] = allocDest; mPc[mTail] = allocPc;
        if (allocHasDest && !allocIsStore) begin mapP[allocDest] = 1; mapT[allocDest] = mTail; end
        mTail = (mTail + 1) % ND; mCount++;
      end
    end
    @(negedge clk);
    idle();
  endtask

  function automatic int pickPending(int avoid);
    int start, idx;
    if (mCount == 0) return -1;
    start = $urandom_range(0, mCount - 1);
    for (int i = 0; i < mCount; i++) begin
      idx = (mHead + ((start + i) % mCount)) % ND;
      if (!mDone[idx] && idx != avoid) return idx;
    end
    return -1;
  endfunction

  task automatic setAlloc(bit st, bit hd, int dst);
    allocValid = 1; allocIsStore = st; allocHasDest = hd;
    allocDest = 4'(dst); allocPc = $urandom & 32'hFFFF_FFFC;
  endtask

  task automatic setCmpl(int k, int tag, bit exc);
    cmplValid[k] = 1; cmplTag[k] = 4'(tag); cmplExc[k] = exc;
    cmplData[k] = $urandom; cmplAddr[k] = $urandom;
  endtask

  task automatic drainAll();
    int a, b;
    for (int i = 0; i < 40 && mCount > 0; i++) begin
      a = pickPending(-1);
      if (a >= 0) setCmpl(0, a, 0);
      b = pickPending(a);
      if (b >= 0) setCmpl(1, b, 0);
      stepCycle();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run exceeded cycle limit actual=150000 expected<150000");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    int tagA, tagB, tagD, tagBefore, a, b;
    void'($urandom(32'd2024));
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    chk("R1", "allocReady", allocReady, 1);
    chk("R1", "allocTag", allocTag, 0);
    chk("R1", "rfWrEn", rfWrEn, 0);
    chk("R1", "stWrEn", stWrEn, 0);
    chk("R1", "flushOut", flushOut, 0);
    for (int r = 0; r < ND; r++) begin
      lookupReg = 4'(r);
      #0.1;
      chk("R1", "lookupPending", lookupPending, 0);
    end
    @(negedge clk);
    idle();

    // R4/R5: out-of-order completion, in-order commit, and a store
    setAlloc(0, 1, 1); stepCycle();
    setAlloc(0, 1, 2); stepCycle();
    setAlloc(1, 0, 0); stepCycle();
    setCmpl(0, 2, 0); stepCycle();
    setCmpl(0, 1, 0); lookupReg = 2; stepCycle();
    setCmpl(1, 0, 0); lookupReg = 1; stepCycle();
    repeat (4) stepCycle();

    // R6: no-write entry retires silently
    setAlloc(0, 0, 0); stepCycle();
    setCmpl(0, mHead, 0); stepCycle();
    stepCycle();
    chk("R6", "slot freed", allocTag, mTail);

    // R3: fill, then attempt an allocation while full
    while (mCount < ND) begin
      setAlloc($urandom_range(0, 3) == 0, 1, $urandom_range(0, 15));
      stepCycle();
    end
    tagBefore = allocTag;
    chk("R3", "allocReady when full", allocReady, 0);
    setAlloc(0, 1, 9); stepCycle();
    chk("R3", "allocTag after ignored alloc", allocTag, tagBefore);
    drainAll();
    repeat (2) stepCycle();

    // R10: younger producer's mapping survives an older commit
    tagA = mTail; setAlloc(0, 1, 5); stepCycle();
    tagB = mTail; setAlloc(0, 1, 5); stepCycle();
    setCmpl(0, tagA, 0); stepCycle();
    stepCycle();
    lookupReg = 5;
    #0.1;
    chk("R10", "lookupPending after older commit", lookupPending, 1);
    chk("R10", "lookupTag after older commit", lookupTag, tagB);
    stepCycle();

    // R9: same-cycle completion forwarded to lookup
    setCmpl(0, tagB, 0); lookupReg = 5;
    #0.1;
    chk("R9", "lookupReady forwarded", lookupReady, 1);
    chk("R9", "lookupValue forwarded", lookupValue, cmplData[0]);
    stepCycle();
    repeat (2) stepCycle();

    // R7/R11: exception at the head
    tagD = mTail; setAlloc(0, 1, 2); stepCycle();
    setAlloc(0, 1, 3); stepCycle();
    setAlloc(1, 0, 0); stepCycle();
    setCmpl(0, tagD, 1); setCmpl(1, (tagD + 1) % ND, 0); stepCycle();
    chk("R7", "flushOut at faulting head", flushOut, 1);
    setAlloc(0, 1, 4); stepCycle();
    lookupReg = 3;
    #0.1;
    chk("R7", "lookupPending after flush", lookupPending, 0);
    chk("R7", "allocTag after flush", allocTag, tagD);
    stepCycle();

    // Random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if ($urandom_range(0, 9) < 6) begin
        if ($urandom_range(0, 3) == 0) setAlloc(1, 0, 0);
        else setAlloc(0, $urandom_range(0, 9) < 7, $urandom_range(0, 15));
      end
      a = -1;
      if ($urandom_range(0, 1) == 1) begin
        a = pickPending(-1);
        if (a >= 0) setCmpl(0, a, $urandom_range(0, 39) == 0);
      end
      if ($urandom_range(0, 1) == 1) begin
        b = pickPending(a);
        if (b >= 0) setCmpl(1, b, $urandom_range(0, 39) == 0);
      end
      lookupReg = 4'($urandom_range(0, 15));
      stepCycle();
    end
    drainAll();
    repeat (3) stepCycle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule